// File: doc/BRIEF.md
# Adaptive PROM programming sequencer

This block is a host-side controller that burns a byte-wide PROM one byte at a time. It walks an address window in ascending order and pulls each byte from a data source over a valid/ready handshake. For each byte it repeats a cycle of one fixed-length program strobe followed by a read-back. It counts the strobes until the byte reads back correctly. If the byte still does not match after the retry limit, programming stops. Once the byte matches, the block applies one extra overprogram strobe. Its length is the base pulse length times the number of strobes that byte needed, and a read-back of the byte follows.

After the last address, the block drops its voltage-mode flags to the nominal level. It fetches every byte a second time from the source and compares each one against the PROM contents. It then reports the result on `done_o` and `fail_o`. On any failure it latches the address that failed. All durations are derived in clock cycles from a clock-frequency parameter. The 0.2 ms pulse and the roughly 2 µs setup window are further parameters. A pulse-limit parameter (default 25) and two address-window parameters (default 0x01000 to 0x1FFFF) complete the set.

Top module: `prom_prog_seq`

## Requirements
- R1: Reset state and idle outputs:
  - all PROM strobes are inactive: `prom_ce_n_o`, `prom_oe_n_o` and `prom_pgm_n_o` are 1;
  - `prom_dout_en_o`, `src_ready_o`, both voltage flags, `done_o` and `fail_o` are 0.
- R2: Start and address order:
  - a `start_i` pulse while idle, done or failed begins a run that raises `vcc_hi_o` and `vpp_hi_o` for the whole programming pass;
  - bytes are requested with `src_ready_o` at addresses FIRST_ADDR, FIRST_ADDR+1, ..., LAST_ADDR, in that order.
- R3: Setup and strobe width:
  - before every program strobe, `prom_ce_n_o`=0, `prom_oe_n_o`=1 and `prom_dout_en_o`=1 hold for at least SETUP cycles (CLK_KHZ*SETUP_US/1000, minimum 1);
  - each normal strobe holds `prom_pgm_n_o` low for exactly PULSE cycles (CLK_KHZ*PULSE_US/1000);
  - address and data are stable while the strobe is low.
- R4: Read-back and pulse count:
  - after every strobe the block reads back with `prom_oe_n_o`=0 and the data driver released;
  - a byte that first matches after X strobes has received exactly X normal strobes.
- R5: Overprogram strobe: after the first match, exactly one overprogram strobe of PULSE*X cycles is applied to that byte.
- R6: Retry limit:
  - a byte that still mismatches after MAX_PULSES strobes ends the run with `fail_o`=1 and `done_o`=1;
  - `fail_addr_o` holds that byte's address and no further strobes are issued.
- R7: Overprogram check: a mismatch in the read-back after the overprogram strobe ends the run with `fail_o`=1 and `fail_addr_o` set to that address.
- R8: Final verify:
  - after LAST_ADDR both voltage flags are 0;
  - every byte is requested again in ascending order and read, and no program strobe occurs;
  - a mismatch gives `fail_o`=1 with `fail_addr_o` set to that address.
- R9: A run without any mismatch ends with `done_o`=1 and `fail_o`=0, and both hold until the next start.
- R10: While waiting for a source byte (`src_ready_o`=1 and `src_valid_i`=0), the block stays stalled with no strobe active. A byte is taken only in a cycle with both `src_valid_i` and `src_ready_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a programming run |
| src_ready_o | output | 1 | Block requests the byte for the current address |
| src_valid_i | input | 1 | Source byte valid |
| src_data_i | input | 8 | Source byte |
| prom_addr_o | output | ADDR_W | PROM address |
| prom_dout_o | output | 8 | Data driven to the PROM |
| prom_dout_en_o | output | 1 | Enable of the data driver |
| prom_din_i | input | 8 | Data read from the PROM |
| prom_ce_n_o | output | 1 | Chip enable, active low |
| prom_oe_n_o | output | 1 | Output enable, active low |
| prom_pgm_n_o | output | 1 | Program strobe, active low |
| vcc_hi_o | output | 1 | Request the raised core supply |
| vpp_hi_o | output | 1 | Request the programming voltage |
| done_o | output | 1 | Run finished |
| fail_o | output | 1 | Run finished with a failure |
| fail_addr_o | output | ADDR_W | Address of the failing byte |

## Verification
Two things can coincide in one cycle: the end of the read-back that closes a byte, and the transition that loads the next address or that starts the final verify pass. Both happen in the same cycle at LAST_ADDR. This coincidence is provoked by byte patterns that need one strobe, several strobes, or more strobes than allowed, and by a source that stalls for a varying number of cycles. It is judged by the model's record of each PROM address, which holds the strobe count and the width of the last strobe. Any strobe during the final pass, any request at an unexpected address, and any mismatch of the latched failing address also count against the design.

// File: rtl/prom_seq_pkg.sv
package prom_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_SETUP, S_PULSE, S_VERIFY,
    S_FV_FETCH, S_FV_READ, S_DONE, S_FAIL
  } seq_state_e;
endpackage

// File: rtl/prom_seq_timer.sv
module prom_seq_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] len_i,
  output logic          expired_o
);
  logic [TW-1:0] cnt_q;

  // length N: expired in the Nth cycle after load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= len_i - TW'(1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - TW'(1);
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/prom_seq_addr.sv
module prom_seq_addr #(
  parameter int              AW    = 17,
  parameter logic [AW-1:0]   FIRST = '0,
  parameter logic [AW-1:0]   LAST  = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_o <= FIRST;
    else if (load_i)  addr_o <= FIRST;
    else if (inc_i)   addr_o <= addr_o + AW'(1);
  end

  assign last_o = (addr_o == LAST);
endmodule

// File: rtl/prom_prog_seq.sv
module prom_prog_seq
  import prom_seq_pkg::*;
#(
  parameter int                ADDR_W     = 17,
  parameter logic [ADDR_W-1:0] FIRST_ADDR = 17'h01000,
  parameter logic [ADDR_W-1:0] LAST_ADDR  = 17'h1FFFF,
  parameter int                CLK_KHZ    = 25000,
  parameter int                PULSE_US   = 200,
  parameter int                SETUP_US   = 2,
  parameter int                MAX_PULSES = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              src_ready_o,
  input  logic              src_valid_i,
  input  logic [7:0]        src_data_i,
  output logic [ADDR_W-1:0] prom_addr_o,
  output logic [7:0]        prom_dout_o,
  output logic              prom_dout_en_o,
  input  logic [7:0]        prom_din_i,
  output logic              prom_ce_n_o,
  output logic              prom_oe_n_o,
  output logic              prom_pgm_n_o,
  output logic              vcc_hi_o,
  output logic              vpp_hi_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o
);
  localparam int PULSE_CYC = CLK_KHZ * PULSE_US / 1000;
  localparam int SETUP_RAW = CLK_KHZ * SETUP_US / 1000;
  localparam int SETUP_CYC = (SETUP_RAW < 1) ? 1 : SETUP_RAW;
  localparam int XW        = $clog2(MAX_PULSES + 1);
  localparam int TW        = $clog2(PULSE_CYC * MAX_PULSES + 1);

  seq_state_e        st_q, st_d;
  logic [7:0]        data_q;
  logic [XW-1:0]     x_q;
  logic              over_q;
  logic [ADDR_W-1:0] fail_addr_q;

  logic          tmr_exp, tmr_load, is_last, match, take;
  logic          addr_load, addr_inc;
  logic [TW-1:0] tmr_len, pulse_len;

  assign match = (prom_din_i == data_q);
  assign take  = src_valid_i && src_ready_o;

  prom_seq_timer #(.TW(TW)) u_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .len_i(tmr_len), .expired_o(tmr_exp)
  );

  prom_seq_addr #(.AW(ADDR_W), .FIRST(FIRST_ADDR), .LAST(LAST_ADDR)) u_addr (
    .clk_i, .rst_ni, .load_i(addr_load), .inc_i(addr_inc),
    .addr_o(prom_addr_o), .last_o(is_last)
  );

  always_comb begin
    st_d      = st_q;
    addr_load = 1'b0;
    addr_inc  = 1'b0;
    unique case (st_q)
      S_IDLE, S_DONE, S_FAIL: if (start_i) begin
        st_d = S_FETCH; addr_load = 1'b1;
      end
      S_FETCH:  if (take) st_d = S_SETUP;
      S_SETUP:  if (tmr_exp) st_d = S_PULSE;
      S_PULSE:  if (tmr_exp) st_d = S_VERIFY;
      S_VERIFY: if (tmr_exp) begin
        if (match) begin
          if (!over_q)      st_d = S_SETUP;
          else if (is_last) begin st_d = S_FV_FETCH; addr_load = 1'b1; end
          else              begin st_d = S_FETCH;    addr_inc  = 1'b1; end
        end else if (over_q || x_q == XW'(MAX_PULSES)) begin
          st_d = S_FAIL;
        end else begin
          st_d = S_SETUP;
        end
      end
      S_FV_FETCH: if (take) st_d = S_FV_READ;
      S_FV_READ:  if (tmr_exp) begin
        if (!match)       st_d = S_FAIL;
        else if (is_last) st_d = S_DONE;
        else begin st_d = S_FV_FETCH; addr_inc = 1'b1; end
      end
      default: st_d = S_IDLE;
    endcase
  end

  // overprogram strobe scales with the pulses the byte needed
  assign pulse_len = over_q ? TW'(PULSE_CYC) * TW'(x_q) : TW'(PULSE_CYC);
  assign tmr_load  = (st_d != st_q);
  always_comb begin
    unique case (st_d)
      S_PULSE:                     tmr_len = pulse_len;
      S_SETUP, S_VERIFY, S_FV_READ: tmr_len = TW'(SETUP_CYC);
      default:                     tmr_len = TW'(1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      data_q      <= '0;
      x_q         <= '0;
      over_q      <= 1'b0;
      fail_addr_q <= '0;
    end else begin
      st_q <= st_d;
      if (take) data_q <= src_data_i;
      if (st_q == S_FETCH && take) begin
        x_q    <= '0;
        over_q <= 1'b0;
      end
      if (st_q == S_PULSE && tmr_exp && !over_q) x_q <= x_q + XW'(1);
      if (st_q == S_VERIFY && tmr_exp && match && !over_q) over_q <= 1'b1;
      if (st_d == S_FAIL && st_q != S_FAIL) fail_addr_q <= prom_addr_o;
    end
  end

  assign src_ready_o    = (st_q == S_FETCH) || (st_q == S_FV_FETCH);
  assign prom_dout_o    = data_q;
  assign prom_dout_en_o = (st_q == S_SETUP) || (st_q == S_PULSE);
  assign prom_pgm_n_o   = (st_q != S_PULSE);
  assign prom_oe_n_o    = !((st_q == S_VERIFY) || (st_q == S_FV_READ));
  assign prom_ce_n_o    = !((st_q == S_SETUP) || (st_q == S_PULSE) ||
                            (st_q == S_VERIFY) || (st_q == S_FV_READ));
  assign vcc_hi_o       = (st_q == S_FETCH) || (st_q == S_SETUP) ||
                          (st_q == S_PULSE) || (st_q == S_VERIFY);
  assign vpp_hi_o       = vcc_hi_o;
  assign done_o         = (st_q == S_DONE) || (st_q == S_FAIL);
  assign fail_o         = (st_q == S_FAIL);
  assign fail_addr_o    = fail_addr_q;
endmodule

// File: rtl/prom_prog_seq_chk.sv
module prom_prog_seq_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              src_ready_o,
  input logic [ADDR_W-1:0] prom_addr_o,
  input logic [7:0]        prom_dout_o,
  input logic              prom_dout_en_o,
  input logic              prom_ce_n_o,
  input logic              prom_oe_n_o,
  input logic              prom_pgm_n_o,
  input logic              vpp_hi_o,
  input logic              done_o,
  input logic              fail_o
);
  a_r3_strobe_conditions: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prom_pgm_n_o |-> prom_oe_n_o && !prom_ce_n_o && prom_dout_en_o && vpp_hi_o);

  a_r3_setup_before_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(prom_pgm_n_o) |-> $past(!prom_ce_n_o && prom_oe_n_o && prom_dout_en_o));

  a_r3_stable_in_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prom_pgm_n_o && $past(!prom_pgm_n_o)) |-> $stable(prom_addr_o) && $stable(prom_dout_o));

  a_r4_read_releases_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prom_oe_n_o |-> !prom_dout_en_o && prom_pgm_n_o && !prom_ce_n_o);

  a_r10_idle_while_waiting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_ready_o |-> prom_pgm_n_o && prom_ce_n_o);

  a_r9_result_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o && $stable(fail_o));

  a_r6_fail_is_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> done_o && prom_ce_n_o);
endmodule

bind prom_prog_seq prom_prog_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .src_ready_o(src_ready_o),
  .prom_addr_o(prom_addr_o), .prom_dout_o(prom_dout_o),
  .prom_dout_en_o(prom_dout_en_o), .prom_ce_n_o(prom_ce_n_o),
  .prom_oe_n_o(prom_oe_n_o), .prom_pgm_n_o(prom_pgm_n_o),
  .vpp_hi_o(vpp_hi_o), .done_o(done_o), .fail_o(fail_o)
);

// File: tb/prom_prog_seq_tb.sv
module prom_prog_seq_tb;
  localparam int AW = 17;
  localparam logic [AW-1:0] FIRST = 17'h01000;
  localparam logic [AW-1:0] LAST  = 17'h01007;
  localparam int N = 8;
  localparam int PULSE = 200;   // 1000 kHz * 200 us
  localparam int SETUP = 2;     // 1000 kHz * 2 us
  localparam int MAXP  = 25;
  // {needed pulses, byte}
  localparam logic [15:0] TAB [N] = '{
    {8'd1, 8'h5A}, {8'd3, 8'hC3}, {8'd2, 8'h01}, {8'd5, 8'h80},
    {8'd1, 8'h3C}, {8'd4, 8'hE7}, {8'd2, 8'h00}, {8'd1, 8'h96}};

  logic clk_i = 0, rst_ni = 0, start_i = 0;
  logic src_ready_o, src_valid_i = 0;
  logic [7:0] src_data_i = 0;
  logic [AW-1:0] prom_addr_o, fail_addr_o;
  logic [7:0] prom_dout_o, prom_din_i = 8'hFF;
  logic prom_dout_en_o, prom_ce_n_o, prom_oe_n_o, prom_pgm_n_o;
  logic vcc_hi_o, vpp_hi_o, done_o, fail_o;

  always #10 clk_i = ~clk_i;

  prom_prog_seq #(.ADDR_W(AW), .FIRST_ADDR(FIRST), .LAST_ADDR(LAST),
    .CLK_KHZ(1000), .PULSE_US(200), .SETUP_US(2), .MAX_PULSES(MAXP)) u_dut (.*);

  int checks = 0, errors = 0;
  // model and monitor state
  int tot [N]; int last_w [N];
  int need_ov_idx, need_ov_val, fv_bad_idx, over_bad_idx;
  int w, setup_run, wbad, setup_bad, fv_pulses, stall_bad, addr_bad, volt_bad;
  int xfers, sidx, stall; bit took;

  function automatic int need_of(int i);
    return (i == need_ov_idx) ? need_ov_val : int'(TAB[i][15:8]);
  endfunction

  always @(negedge clk_i) begin
    int idx;
    idx = int'(prom_addr_o - FIRST);
    // strobe width and setup monitor
    if (!prom_pgm_n_o) begin
      if (w == 0 && setup_run < SETUP) setup_bad++;
      w++;
      if (src_ready_o) stall_bad++;
      if (!vpp_hi_o) fv_pulses++;
    end else if (w > 0) begin
      if (idx >= 0 && idx < N) begin
        if (w != PULSE && tot[idx] != need_of(idx)) wbad++;
        tot[idx]++; last_w[idx] = w;
      end
      w = 0;
    end
    if (!prom_ce_n_o && prom_oe_n_o && prom_dout_en_o && prom_pgm_n_o) setup_run++;
    else setup_run = 0;
    // read model
    prom_din_i = 8'hFF;
    if (!prom_ce_n_o && !prom_oe_n_o && idx >= 0 && idx < N) begin
      if (tot[idx] >= need_of(idx)) prom_din_i = TAB[idx][7:0];
      if (idx == over_bad_idx && tot[idx] > need_of(idx)) prom_din_i ^= 8'h80;
      if (idx == fv_bad_idx && !vpp_hi_o) prom_din_i ^= 8'h01;
    end
    // source with varying stall
    if (took) begin
      xfers++; sidx = (sidx + 1) % N; src_valid_i = 0; stall = (sidx * 3) % 4;
    end
    if (!src_valid_i) begin
      if (stall == 0) begin src_valid_i = 1; src_data_i = TAB[sidx][7:0]; end
      else stall--;
    end
    took = src_valid_i && src_ready_o;
    if (took) begin
      if (prom_addr_o != FIRST + AW'(sidx)) addr_bad++;
      if ((xfers < N) != vpp_hi_o || vcc_hi_o != vpp_hi_o) volt_bad++;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(int nidx, int nval, int fvb, int ovb);
    int cyc;
    @(posedge clk_i); #1;
    foreach (tot[i]) begin tot[i] = 0; last_w[i] = 0; end
    need_ov_idx = nidx; need_ov_val = nval; fv_bad_idx = fvb; over_bad_idx = ovb;
    wbad = 0; setup_bad = 0; fv_pulses = 0; stall_bad = 0; addr_bad = 0; volt_bad = 0;
    xfers = 0; sidx = 0; stall = 2; took = 0; src_valid_i = 0; w = 0; setup_run = 0;
    start_i = 1;
    @(posedge clk_i); #1; start_i = 0;
    @(negedge clk_i);
    chk(done_o == 0, "R2 done drops", done_o, 0);
    chk(vpp_hi_o && vcc_hi_o, "R2 flags raised", vpp_hi_o, 1);
    cyc = 0;
    while (!done_o && cyc < 60000) begin @(negedge clk_i); cyc++; end
    chk(cyc < 60000, "watchdog", cyc, 0);
    repeat (3) @(negedge clk_i);
    chk(done_o == 1, "R9 done held", done_o, 1);
  endtask

  initial begin
    need_ov_idx = -1; need_ov_val = 0; fv_bad_idx = -1; over_bad_idx = -1;
    w = 0; setup_run = 0; took = 0; sidx = 0; stall = 0; xfers = 0;
    foreach (tot[i]) begin tot[i] = 0; last_w[i] = 0; end
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(prom_ce_n_o && prom_oe_n_o && prom_pgm_n_o, "R1 strobes idle", prom_pgm_n_o, 1);
    chk(!src_ready_o && !prom_dout_en_o, "R1 no request", src_ready_o, 0);
    chk(!vcc_hi_o && !vpp_hi_o && !done_o && !fail_o, "R1 flags low", done_o, 0);
    rst_ni = 1;
    repeat (5) @(negedge clk_i);
    chk(prom_pgm_n_o && !src_ready_o, "R1 idle without start", src_ready_o, 0);

    // clean run: table walk
    run(-1, 0, -1, -1);
    chk(fail_o == 0, "R9 pass", fail_o, 0);
    for (int i = 0; i < N; i++) begin
      chk(tot[i] == int'(TAB[i][15:8]) + 1, "R4 strobes per byte", tot[i], int'(TAB[i][15:8]) + 1);
      chk(last_w[i] == int'(TAB[i][15:8]) * PULSE, "R5 overprogram width", last_w[i], int'(TAB[i][15:8]) * PULSE);
    end
    chk(wbad == 0, "R3 normal strobe width", wbad, 0);
    chk(setup_bad == 0, "R3 setup window", setup_bad, 0);
    chk(addr_bad == 0, "R2 address order", addr_bad, 0);
    chk(volt_bad == 0, "R8 voltage flags per pass", volt_bad, 0);
    chk(fv_pulses == 0, "R8 no strobe in final verify", fv_pulses, 0);
    chk(xfers == 2 * N, "R8 bytes fetched twice", xfers, 2 * N);
    chk(stall_bad == 0, "R10 no strobe while stalled", stall_bad, 0);

    // retry limit
    run(3, MAXP + 1, -1, -1);
    chk(fail_o == 1, "R6 fail", fail_o, 1);
    chk(fail_addr_o == FIRST + 17'd3, "R6 fail address", int'(fail_addr_o), int'(FIRST) + 3);
    chk(tot[3] == MAXP, "R6 pulse cap", tot[3], MAXP);
    chk(tot[4] == 0, "R6 stops", tot[4], 0);

    // exactly at the limit passes
    run(3, MAXP, -1, -1);
    chk(fail_o == 0, "R6 limit reached passes", fail_o, 0);
    chk(last_w[3] == MAXP * PULSE, "R5 longest overprogram", last_w[3], MAXP * PULSE);

    // overprogram verify failure
    run(-1, 0, -1, 2);
    chk(fail_o == 1, "R7 fail", fail_o, 1);
    chk(fail_addr_o == FIRST + 17'd2, "R7 fail address", int'(fail_addr_o), int'(FIRST) + 2);
    chk(tot[3] == 0, "R7 stops", tot[3], 0);

    // final verify mismatch at last byte
    run(-1, 0, 7, -1);
    chk(fail_o == 1, "R8 fail", fail_o, 1);
    chk(fail_addr_o == LAST, "R8 fail address", int'(fail_addr_o), int'(LAST));
    chk(fv_pulses == 0, "R8 no strobe", fv_pulses, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule